// File: doc/BRIEF.md
# Byte-Lane Load/Store Alignment Unit

This unit lets a processor core address every byte of a data memory that is physically organised as 32-bit words. A request carries a byte address, an access size of one, two or four bytes, a direction, and a flag that picks sign or zero extension for narrow loads. The low two address bits select a lane inside a word, and the remaining bits select the word. Stores are steered onto the correct lanes with per-lane write enables, so only the addressed bytes change. Loads pick the addressed bytes out of the fetched word and then extend the result to 32 bits.

When an access runs past the end of a word, the unit issues two aligned memory cycles in a row. The first cycle goes to the lower word and the second to the next word, wrapping from the top word to word 0. The two halves of a load are merged before extension. The `big_endian` input selects how the bytes of a multibyte value map onto rising addresses, and it is sampled together with each request. The word memory is a synchronous single-port RAM inside the block, so the port list is just the core-side request and response.

Top module: `bytelane_lsu`

## Requirements
- R1: During reset and in the first cycle after reset is released, `req_ready` is 1 and `rsp_valid` is 0.
- R2: An access that stays inside one word is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 for the one cycle that follows that edge, and `req_ready` stays 1.
- R3: Memory word index is byte address / 4, and the lane is byte address mod 4. Lane L occupies bits [8L+7:8L] of the memory word. A one-byte load returns the addressed lane (size code 0).
- R4: For byte loads (size 0) and halfword loads (size 1), `req_signed`=1 copies bit 7 or bit 15 into all upper bits, and `req_signed`=0 fills the upper bits with zeros. Word loads (size 2) are returned unchanged.
- R5: With `big_endian`=0, byte k of a multibyte value (k=0 least significant) is at address A+k. A word store of 0x12345678 at A reads back as bytes 78, 56, 34, 12 at A..A+3.
- R6: With `big_endian`=1, the most significant byte is at address A. The same store reads back as bytes 12, 34, 56, 78.
- R7: A store changes only the bytes at addresses A..A+n-1, where n is 1, 2 or 4. All other bytes of the touched words keep their values.
- R8: An access where (address mod 4) + n > 4 uses two memory cycles. `req_ready` is 0 in the cycle after acceptance, and `rsp_valid` is 1 only in the second cycle after acceptance.
- R9: A word-straddling access reads or writes the correct bytes in both words, including the wrap from the top word to word 0. A straddling load returns the merged, extended value.
- R10: Size code 3 behaves exactly like a word access (size code 2).
- R11: `rsp_valid` is 1 exactly once per accepted request. It is never 1 while no request is pending, and it is never 1 while `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian | input | 1 | 1 selects most-significant-byte-first ordering; sampled with the request |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 treated as word |
| req_signed | input | 1 | Sign-extend narrow loads when 1 |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store value, right-justified |
| rsp_valid | output | 1 | Access finished; load data valid |
| rsp_rdata | output | 32 | Extended load result |

## Verification
The visible symptoms depend on where the internal state goes wrong. A wrong lane offset or byte-order choice shows up as permuted bytes on the very next `rsp_rdata`. A missing write enable shows up as a corrupted neighbour byte the next time that word is loaded. A sequencer that mishandles the second half of a split access shows up within two cycles: `req_ready` stays high too long, `rsp_valid` arrives early, or the upper word is never written. The stimulus covers every lane offset, every size, both extensions and both byte orders against a byte-array model. It also targets the top-word wrap and the reserved size code.

// File: rtl/bl_pkg.sv
package bl_pkg;

    localparam int LANES  = 4;
    localparam int WORD_W = 8 * LANES;
    localparam int OFF_W  = $clog2(LANES);
    localparam int WIN_W  = 2 * WORD_W;
    localparam int WIN_LN = 2 * LANES;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_HIGH = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [OFF_W-1:0] off;
        acc_size_e        size;
        logic             sgn;
        logic             big;
    } lane_attr_t;

    function automatic logic [2:0] nbytes(acc_size_e s);
        case (s)
            SZ_BYTE: nbytes = 3'd1;
            SZ_HALF: nbytes = 3'd2;
            default: nbytes = 3'd4;
        endcase
    endfunction

    function automatic logic straddles(logic [OFF_W-1:0] off, acc_size_e s);
        straddles = (3'(off) + nbytes(s)) > 3'(LANES);
    endfunction

endpackage

// File: rtl/bl_lane_pack.sv
module bl_lane_pack
    import bl_pkg::*;
(
    input  logic [WORD_W-1:0] wdata,
    input  lane_attr_t        attr,
    output logic [WIN_W-1:0]  win_data,
    output logic [WIN_LN-1:0] win_be
);
    int n;
    int src;
    int pos;

    always_comb begin
        win_data = '0;
        win_be   = '0;
        n        = int'(nbytes(attr.size));
        src      = 0;
        pos      = 0;
        for (int k = 0; k < LANES; k++) begin
            if (k < n) begin
                src = attr.big ? (n - 1 - k) : k;
                pos = int'(attr.off) + k;
                win_data[8*pos +: 8] = wdata[8*src +: 8];
                win_be[pos]          = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bl_lane_unpack.sv
module bl_lane_unpack
    import bl_pkg::*;
(
    input  logic [WIN_W-1:0]  win,
    input  lane_attr_t        attr,
    output logic [WORD_W-1:0] value
);
    int n;
    int dst;
    int pos;
    logic [WORD_W-1:0] raw;

    always_comb begin
        raw = '0;
        n   = int'(nbytes(attr.size));
        dst = 0;
        pos = 0;
        for (int k = 0; k < LANES; k++) begin
            if (k < n) begin
                pos = int'(attr.off) + k;
                dst = attr.big ? (n - 1 - k) : k;
                raw[8*dst +: 8] = win[8*pos +: 8];
            end
        end
    end

    always_comb begin
        case (attr.size)
            SZ_BYTE: value = {{(WORD_W-8){attr.sgn & raw[7]}}, raw[7:0]};
            SZ_HALF: value = {{(WORD_W-16){attr.sgn & raw[15]}}, raw[15:0]};
            default: value = raw;
        endcase
    end
endmodule

// File: rtl/bl_word_ram.sv
module bl_word_ram
    import bl_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    input  logic              we,
    input  logic [LANES-1:0]  be,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int WORDS = 1 << IDX_W;

    logic [WORD_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= mem[idx];
    end

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (we && be[l]) mem[idx][8*l +: 8] <= wdata[8*l +: 8];
        end
    end
endmodule

// File: rtl/bytelane_lsu.sv
module bytelane_lsu
    import bl_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              big_endian,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata
);
    localparam int IDX_W = ADDR_W - OFF_W;

    seq_state_e        state;
    lane_attr_t        req_attr, rsp_attr;
    logic [IDX_W-1:0]  req_idx, hi_idx, ram_idx;
    logic              req_cross, accept;
    logic [WIN_W-1:0]  pk_win;
    logic [WIN_LN-1:0] pk_be;
    logic [WORD_W-1:0] hi_data, ram_wdata, ram_rdata, lo_hold;
    logic [LANES-1:0]  hi_be, ram_be;
    logic              hi_write, ram_we;
    logic              rsp_valid_q, rsp_split;
    logic [WIN_W-1:0]  rsp_win;

    assign req_attr  = '{off: req_addr[OFF_W-1:0], size: acc_size_e'(req_size),
                         sgn: req_signed, big: big_endian};
    assign req_idx   = req_addr[ADDR_W-1:OFF_W];
    assign req_cross = straddles(req_attr.off, req_attr.size);
    assign req_ready = (state == SEQ_IDLE);
    assign accept    = req_valid && req_ready;

    bl_lane_pack u_pack (
        .wdata    (req_wdata),
        .attr     (req_attr),
        .win_data (pk_win),
        .win_be   (pk_be)
    );

    always_comb begin
        if (state == SEQ_HIGH) begin
            ram_idx   = hi_idx;
            ram_we    = hi_write;
            ram_be    = hi_be;
            ram_wdata = hi_data;
        end else begin
            ram_idx   = req_idx;
            ram_we    = accept && req_write;
            ram_be    = pk_be[LANES-1:0];
            ram_wdata = pk_win[WORD_W-1:0];
        end
    end

    bl_word_ram #(.IDX_W(IDX_W)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .idx   (ram_idx),
        .we    (ram_we),
        .be    (ram_be),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SEQ_IDLE;
            rsp_valid_q <= 1'b0;
            rsp_split   <= 1'b0;
            lo_hold     <= '0;
            hi_idx      <= '0;
            hi_data     <= '0;
            hi_be       <= '0;
            hi_write    <= 1'b0;
            rsp_attr    <= '0;
        end else begin
            rsp_valid_q <= (accept && !req_cross) || (state == SEQ_HIGH);
            rsp_split   <= (state == SEQ_HIGH);
            if (state == SEQ_HIGH) begin
                lo_hold <= ram_rdata;
                state   <= SEQ_IDLE;
            end else if (accept) begin
                rsp_attr <= req_attr;
                if (req_cross) begin
                    state    <= SEQ_HIGH;
                    hi_idx   <= req_idx + IDX_W'(1);
                    hi_data  <= pk_win[WIN_W-1:WORD_W];
                    hi_be    <= pk_be[WIN_LN-1:LANES];
                    hi_write <= req_write;
                end
            end
        end
    end

    assign rsp_win = rsp_split ? {ram_rdata, lo_hold} : {{WORD_W{1'b0}}, ram_rdata};

    bl_lane_unpack u_unpack (
        .win   (rsp_win),
        .attr  (rsp_attr),
        .value (rsp_rdata)
    );

    assign rsp_valid = rsp_valid_q;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !rsp_valid));

    // R2
    aligned_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_cross) |=> (rsp_valid && req_ready));

    // R8
    split_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && req_cross) |=> (!req_ready && !rsp_valid));

    // R8
    split_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && req_cross) |-> ##2 rsp_valid);

    // R9
    split_hi_write_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && req_cross && req_write) |=>
            (ram_we && (ram_be != '0) && (ram_idx == $past(req_idx) + IDX_W'(1))));

    // R7
    lane_count_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> ($countones(pk_be) == int'(nbytes(req_attr.size))));

    // R4
    zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_attr.sgn && rsp_attr.size == SZ_BYTE) |-> (rsp_rdata[31:8] == '0));

    // R11
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> !rsp_valid);

endmodule

// File: tb/bytelane_lsu_test.sv
module bytelane_lsu_test;
    localparam int AW = 10;
    localparam int NB = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          big_endian, req_valid, req_ready, req_write, req_signed;
    logic [1:0]    req_size;
    logic [AW-1:0] req_addr;
    logic [31:0]   req_wdata, rsp_rdata;
    logic          rsp_valid;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] ref_mem [NB];

    bytelane_lsu #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .big_endian(big_endian),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    always #5 clk = ~clk;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int sz_n(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic is_split(input int a, input logic [1:0] s);
        return ((a % 4) + sz_n(s)) > 4;
    endfunction

    function automatic logic [31:0] model_load(input int a, input logic [1:0] s,
                                               input logic sg, input logic bm);
        int n = sz_n(s);
        logic [31:0] v = '0;
        for (int k = 0; k < n; k++) begin
            if (bm) v[8*(n-1-k) +: 8] = ref_mem[(a + k) % NB];
            else    v[8*k +: 8]       = ref_mem[(a + k) % NB];
        end
        if (n == 1 && sg && v[7])  v[31:8]  = '1;
        if (n == 2 && sg && v[15]) v[31:16] = '1;
        return v;
    endfunction

    task automatic access(input logic w, input int a, input logic [1:0] s, input logic sg,
                          input logic [31:0] d, input logic bm,
                          output logic [31:0] rd, output int lat, output logic rdy1);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_size = s;
        req_signed = sg; req_wdata = d; big_endian = bm;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rdy1 = req_ready;
        lat = 1;
        while (!rsp_valid && lat < 6) begin
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
    endtask

    task automatic timing_chk(input int a, input logic [1:0] s, input int lat, input logic rdy1);
        if (is_split(a, s)) begin
            chk(32'(lat), 32'd2, "R8 split latency");
            chk(32'(rdy1), 32'd0, "R8 ready low in second cycle");
        end else begin
            chk(32'(lat), 32'd1, "R2 aligned latency");
            chk(32'(rdy1), 32'd1, "R2 ready stays high");
        end
    endtask

    task automatic do_store(input int a, input logic [1:0] s, input logic [31:0] d, input logic bm);
        logic [31:0] rd; int lat; logic rdy1;
        int n = sz_n(s);
        access(1'b1, a, s, 1'b0, d, bm, rd, lat, rdy1);
        timing_chk(a, s, lat, rdy1);
        for (int k = 0; k < n; k++)
            ref_mem[(a + k) % NB] = bm ? d[8*(n-1-k) +: 8] : d[8*k +: 8];
    endtask

    task automatic do_load(input int a, input logic [1:0] s, input logic sg, input logic bm,
                           input string tag);
        logic [31:0] rd; int lat; logic rdy1;
        access(1'b0, a, s, sg, 32'h0, bm, rd, lat, rdy1);
        timing_chk(a, s, lat, rdy1);
        chk(rd, model_load(a, s, sg, bm), tag);
    endtask

    task automatic load_exp(input int a, input logic [1:0] s, input logic sg, input logic bm,
                            input logic [31:0] exp, input string tag);
        logic [31:0] rd; int lat; logic rdy1;
        access(1'b0, a, s, sg, 32'h0, bm, rd, lat, rdy1);
        chk(rd, exp, tag);
    endtask

    task automatic t_reset();
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
        req_signed = 1'b0; req_addr = '0; req_wdata = '0; big_endian = 1'b0;
        repeat (3) @(negedge clk);
        chk(32'(req_ready), 32'd1, "R1 ready in reset");
        chk(32'(rsp_valid), 32'd0, "R1 rsp_valid in reset");
        rst = 1'b0;
        @(negedge clk);
        chk(32'(req_ready), 32'd1, "R1 ready after reset");
        chk(32'(rsp_valid), 32'd0, "R1 rsp_valid after reset");
    endtask

    task automatic t_fill();
        for (int i = 0; i < 64; i++)
            do_store(4 * i, 2'd2, 32'hA5C3_0000 ^ (32'(i) * 32'h0103_0507), 1'b0);
    endtask

    task automatic t_byte_order();
        do_store(32'h40, 2'd2, 32'h1234_5678, 1'b0);
        load_exp(32'h40, 2'd0, 1'b0, 1'b0, 32'h78, "R5 byte at A");
        load_exp(32'h41, 2'd0, 1'b0, 1'b0, 32'h56, "R5 byte at A+1");
        load_exp(32'h42, 2'd0, 1'b0, 1'b0, 32'h34, "R5 byte at A+2");
        load_exp(32'h43, 2'd0, 1'b0, 1'b0, 32'h12, "R3 byte at A+3");
        do_store(32'h50, 2'd2, 32'h1234_5678, 1'b1);
        load_exp(32'h50, 2'd0, 1'b0, 1'b1, 32'h12, "R6 byte at A");
        load_exp(32'h51, 2'd0, 1'b0, 1'b1, 32'h34, "R6 byte at A+1");
        load_exp(32'h52, 2'd0, 1'b0, 1'b1, 32'h56, "R6 byte at A+2");
        load_exp(32'h53, 2'd0, 1'b0, 1'b0, 32'h78, "R3 byte at A+3");
        load_exp(32'h50, 2'd2, 1'b0, 1'b1, 32'h1234_5678, "R6 word readback");
    endtask

    task automatic t_extend();
        do_store(32'h61, 2'd0, 32'h85, 1'b0);
        load_exp(32'h61, 2'd0, 1'b1, 1'b0, 32'hFFFF_FF85, "R4 signed byte");
        load_exp(32'h61, 2'd0, 1'b0, 1'b0, 32'h0000_0085, "R4 unsigned byte");
        do_store(32'h62, 2'd1, 32'h8001, 1'b0);
        load_exp(32'h62, 2'd1, 1'b1, 1'b0, 32'hFFFF_8001, "R4 signed half");
        load_exp(32'h62, 2'd1, 1'b0, 1'b0, 32'h0000_8001, "R4 unsigned half");
        do_store(32'h64, 2'd2, 32'h8000_00F0, 1'b0);
        load_exp(32'h64, 2'd2, 1'b1, 1'b0, 32'h8000_00F0, "R4 word unchanged");
    endtask

    task automatic t_partial();
        do_store(32'h70, 2'd2, 32'hAABB_CCDD, 1'b0);
        do_store(32'h72, 2'd0, 32'h11, 1'b0);
        load_exp(32'h70, 2'd2, 1'b0, 1'b0, 32'hAA11_CCDD, "R7 byte store keeps neighbours");
        do_store(32'h70, 2'd1, 32'h2233, 1'b0);
        load_exp(32'h70, 2'd2, 1'b0, 1'b0, 32'hAA11_2233, "R7 half store keeps neighbours");
    endtask

    task automatic t_split();
        do_store(32'h83, 2'd2, 32'hCAFE_BABE, 1'b0);
        load_exp(32'h83, 2'd2, 1'b0, 1'b0, 32'hCAFE_BABE, "R9 split word readback");
        for (int a = 32'h80; a < 32'h88; a++) do_load(a, 2'd0, 1'b0, 1'b0, "R9 bytes around split store");
        do_store(32'h93, 2'd1, 32'hBEEF, 1'b1);
        load_exp(32'h93, 2'd0, 1'b0, 1'b0, 32'hBE, "R9 BE split half low byte");
        load_exp(32'h94, 2'd0, 1'b0, 1'b0, 32'hEF, "R9 BE split half high byte");
        load_exp(32'h93, 2'd1, 1'b1, 1'b1, 32'hFFFF_BEEF, "R9 BE split signed half");
        do_load(32'h92, 2'd0, 1'b0, 1'b0, "R7 byte before split half");
        do_load(32'h95, 2'd0, 1'b0, 1'b0, "R7 byte after split half");
    endtask

    task automatic t_wrap();
        do_store(NB - 4, 2'd2, 32'h0, 1'b0);
        do_store(NB - 2, 2'd2, 32'h0102_0304, 1'b0);
        load_exp(NB - 2, 2'd2, 1'b0, 1'b0, 32'h0102_0304, "R9 wrap word readback");
        load_exp(0, 2'd0, 1'b0, 1'b0, 32'h02, "R9 wrap byte at 0");
        load_exp(1, 2'd0, 1'b0, 1'b0, 32'h01, "R9 wrap byte at 1");
        do_load(2, 2'd0, 1'b0, 1'b0, "R7 wrap byte at 2 untouched");
    endtask

    task automatic t_rsvd();
        load_exp(32'h40, 2'd3, 1'b1, 1'b0, 32'h1234_5678, "R10 size 3 as word");
        do_store(32'h45, 2'd3, 32'h99887766, 1'b1);
        load_exp(32'h45, 2'd2, 1'b0, 1'b1, 32'h9988_7766, "R10 size 3 split store");
    endtask

    task automatic t_sweep();
        for (int bm = 0; bm < 2; bm++)
            for (int s = 0; s < 3; s++)
                for (int sg = 0; sg < 2; sg++)
                    for (int a = 32'h20; a < 32'h28; a++)
                        do_load(a, 2'(s), 1'(sg), 1'(bm), "R3 sweep load");
    endtask

    task automatic t_idle();
        logic seen = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (rsp_valid) seen = 1'b1;
        end
        chk(32'(seen), 32'd0, "R11 no response while idle");
    endtask

    initial begin
        t_reset();
        t_fill();
        t_byte_order();
        t_extend();
        t_partial();
        t_split();
        t_wrap();
        t_rsvd();
        t_sweep();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule